// File: doc/BRIEF.md
# Extended Program Bank Mapper with Protection Readback

This block sits in a cartridge-side address decoder. It watches CPU writes and holds a mode byte, which is loaded by a write to one of two exact addresses in the low cartridge window. That byte can replace the usual 8 KB program bank assignment. The replacement can be a 32 KB window chosen by one of two divisors, or a 16 KB window repeated in both halves of the upper 32 KB. A third choice pairs two shadow registers with the last two banks of the program memory.

The block also keeps the data byte of the most recent CPU write to the cartridge. Reads from the low window return a fixed protection value that depends on the two least significant bits of that byte. Until the first mode write after reset, the four normal slot numbers from the neighbouring mapper logic pass straight through to the bank outputs.

Top module: `prg_ext_map`

## Requirements
- R1: The mode byte resets to 0x00. A write to exactly 0x5000 or 0x6000 loads it, taking effect from the next clock. Writes to any other address, for example 0x5001 or 0x7000, leave it unchanged.
- R2: A write to 0x5000–0x7FFF or to 0x8000–0xFFFF records its data as the last-written byte, which resets to 0x00. Writes below 0x5000 do not change it.
- R3: A read in 0x5000–0x7FFF returns a value chosen by bits [1:0] of the last-written byte: 0x83 for 0 or 1, 0x42 for 2 and 0x00 for 3.
- R4: `rd_oe` is 1 exactly when `addr` lies in 0x5000–0x7FFF, in the same cycle, with no clock needed. Outside that range `rd_data` is 0x00.
- R5: After reset and before any mode write, `bank0`..`bank3` equal `norm_slot0`..`norm_slot3`.
- R6: After a mode write, if mode bit 7 is 0, the bank outputs are `shadow6`, `shadow7`, PRG_BANKS-2 and PRG_BANKS-1.
- R7: If mode bits 7 and 5 are both 1, N = mode[4:0] >> 2 when bit 6 is 1 and N = mode[4:0] >> 1 when bit 6 is 0. The bank outputs are 4N, 4N+1, 4N+2 and 4N+3.
- R8: If mode bit 7 is 1 and bit 5 is 0, then with M = mode[4:0] the bank outputs are 2M, 2M+1, 2M and 2M+1.
- R9: Reset brings back pass-through of the normal slots and a last-written byte of 0x00, so a low-window read returns 0x83.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe for this cycle |
| addr | input | AW | CPU address |
| wdata | input | DW | CPU write data |
| norm_slot0 | input | BW | Normal 8 KB bank for 0x8000 |
| norm_slot1 | input | BW | Normal 8 KB bank for 0xA000 |
| norm_slot2 | input | BW | Normal 8 KB bank for 0xC000 |
| norm_slot3 | input | BW | Normal 8 KB bank for 0xE000 |
| shadow6 | input | BW | Shadow register 6 value |
| shadow7 | input | BW | Shadow register 7 value |
| bank0 | output | BW | Final bank for 0x8000 |
| bank1 | output | BW | Final bank for 0xA000 |
| bank2 | output | BW | Final bank for 0xC000 |
| bank3 | output | BW | Final bank for 0xE000 |
| rd_oe | output | 1 | High when this block answers a read |
| rd_data | output | DW | Protection read value |

## Verification
The assertions assume that `wr_en` and `addr` are stable across each clock edge and that `addr` is a defined value while the block is out of reset. The bench changes its inputs only on the falling edge. It holds a write for exactly one rising edge and then drops `wr_en`.

The mapping properties also assume that PRG_BANKS is at least 2 and that BW is wide enough for 4N+3. The bench keeps the defaults, which satisfy both conditions.

// File: rtl/prg_ext_map.sv
module prg_ext_map #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BW = 8,
  parameter int PRG_BANKS = 32,
  parameter logic [15:0] MODE_ADDR_A = 16'h5000,
  parameter logic [15:0] MODE_ADDR_B = 16'h6000,
  parameter logic [15:0] LOW_LO = 16'h5000,
  parameter logic [15:0] LOW_HI = 16'h7FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] norm_slot0,
  input  logic [BW-1:0] norm_slot1,
  input  logic [BW-1:0] norm_slot2,
  input  logic [BW-1:0] norm_slot3,
  input  logic [BW-1:0] shadow6,
  input  logic [BW-1:0] shadow7,
  output logic [BW-1:0] bank0,
  output logic [BW-1:0] bank1,
  output logic [BW-1:0] bank2,
  output logic [BW-1:0] bank3,
  output logic          rd_oe,
  output logic [DW-1:0] rd_data
);
  localparam logic [BW-1:0] LAST_BANK = BW'(PRG_BANKS - 1);
  localparam logic [BW-1:0] PREV_BANK = BW'(PRG_BANKS - 2);

  logic [DW-1:0] mode_q, last_q;
  logic          ext_seen;

  logic in_low, in_high, mode_hit;
  assign in_low   = (addr >= AW'(LOW_LO)) && (addr <= AW'(LOW_HI));
  assign in_high  = addr[AW-1];
  assign mode_hit = wr_en && (addr == AW'(MODE_ADDR_A) || addr == AW'(MODE_ADDR_B));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      last_q   <= '0;
      ext_seen <= 1'b0;
    end else begin
      if (mode_hit) begin
        mode_q   <= wdata;
        ext_seen <= 1'b1;
      end
      if (wr_en && (in_low || in_high)) last_q <= wdata;
    end
  end

  assign rd_oe = in_low;
  always_comb begin
    rd_data = '0;
    if (in_low)
      case (last_q[1:0])
        2'd2:    rd_data = DW'(8'h42);
        2'd3:    rd_data = DW'(8'h00);
        default: rd_data = DW'(8'h83);
      endcase
  end

  logic [4:0]    sel5;
  logic [3:0]    n32;
  logic [BW-1:0] base32, base16;
  assign sel5   = mode_q[4:0];
  assign n32    = mode_q[6] ? {2'b00, sel5[4:2]} : {1'b0, sel5[4:1]};
  assign base32 = BW'({n32, 2'b00});
  assign base16 = BW'({sel5, 1'b0});

  always_comb begin
    if (!ext_seen) begin
      bank0 = norm_slot0;
      bank1 = norm_slot1;
      bank2 = norm_slot2;
      bank3 = norm_slot3;
    end else if (!mode_q[7]) begin
      bank0 = shadow6;
      bank1 = shadow7;
      bank2 = PREV_BANK;
      bank3 = LAST_BANK;
    end else if (mode_q[5]) begin
      bank0 = base32;
      bank1 = base32 | BW'(1);
      bank2 = base32 | BW'(2);
      bank3 = base32 | BW'(3);
    end else begin
      bank0 = base16;
      bank1 = base16 | BW'(1);
      bank2 = base16;
      bank3 = base16 | BW'(1);
    end
  end
endmodule

// File: rtl/prg_ext_map_chk.sv
module prg_ext_map_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BW = 8,
  parameter int PRG_BANKS = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [BW-1:0] bank0,
  input logic [BW-1:0] bank1,
  input logic [BW-1:0] bank2,
  input logic [BW-1:0] bank3,
  input logic          rd_oe,
  input logic [DW-1:0] rd_data,
  input logic [DW-1:0] mode_q,
  input logic [DW-1:0] last_q,
  input logic          ext_seen
);
  a_r1_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == AW'(16'h5000) || addr == AW'(16'h6000))) |=> (mode_q == $past(wdata)));

  a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));

  a_r2_last_rec: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr >= AW'(16'h5000)) |=> (last_q == $past(wdata)));

  a_r3_read_set: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (rd_data == DW'(8'h83) || rd_data == DW'(8'h42) || rd_data == DW'(8'h00)));

  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0));

  a_r6_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_seen && !mode_q[7]) |-> (bank2 == BW'(PRG_BANKS - 2) && bank3 == BW'(PRG_BANKS - 1)));

  a_r7_window32: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_seen && mode_q[7] && mode_q[5]) |->
      (bank0[1:0] == 2'd0 && bank1 == bank0 + BW'(1) && bank2 == bank0 + BW'(2) && bank3 == bank0 + BW'(3)));

  a_r8_window16: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_seen && mode_q[7] && !mode_q[5]) |->
      (bank0[0] == 1'b0 && bank1 == bank0 + BW'(1) && bank2 == bank0 && bank3 == bank1));
endmodule

bind prg_ext_map prg_ext_map_chk #(.AW(AW), .DW(DW), .BW(BW), .PRG_BANKS(PRG_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .bank0(bank0), .bank1(bank1), .bank2(bank2), .bank3(bank3),
  .rd_oe(rd_oe), .rd_data(rd_data),
  .mode_q(mode_q), .last_q(last_q), .ext_seen(ext_seen)
);

// File: tb/sim_prg_ext_map.sv
module sim_prg_ext_map;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wdata = 8'h00;
  logic [7:0] ns0 = 8'h11, ns1 = 8'h22, ns2 = 8'h33, ns3 = 8'h44;
  logic [7:0] sh6 = 8'h0A, sh7 = 8'h0B;
  logic [7:0] b0, b1, b2, b3, rdat;
  logic oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prg_ext_map u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .norm_slot0(ns0), .norm_slot1(ns1), .norm_slot2(ns2), .norm_slot3(ns3),
    .shadow6(sh6), .shadow7(sh7),
    .bank0(b0), .bank1(b1), .bank2(b2), .bank3(b3), .rd_oe(oe), .rd_data(rdat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_banks(input string tag, input logic [7:0] e0, e1, e2, e3);
    chk(tag, {b0, b1, b2, b3}, {e0, e1, e2, e3});
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 16'h0000;
  endtask

  task automatic do_rd(input logic [15:0] a, input logic [7:0] exp_d, input logic exp_oe, input string tag);
    addr = a;
    #1;
    chk({tag, " oe"}, oe, exp_oe);
    chk({tag, " data"}, rdat, exp_d);
    addr = 16'h0000;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    chk_banks("R5 passthrough after reset", ns0, ns1, ns2, ns3);
    do_rd(16'h5800, 8'h83, 1'b1, "R9 reset readback");
    do_wr(16'h5001, 8'hA5);
    chk_banks("R1 near-miss address ignored", ns0, ns1, ns2, ns3);
    do_wr(16'h7000, 8'hA5);
    chk_banks("R1 0x7000 ignored", ns0, ns1, ns2, ns3);
  endtask

  task automatic t_readback;
    do_wr(16'h8001, 8'h02);
    do_rd(16'h5000, 8'h42, 1'b1, "R3 low bits 2");
    do_wr(16'hFFFF, 8'h07);
    do_rd(16'h7FFF, 8'h00, 1'b1, "R3 low bits 3");
    do_wr(16'h5555, 8'h01);
    do_rd(16'h6000, 8'h83, 1'b1, "R3 low bits 1");
    do_wr(16'h4FFF, 8'h02);
    do_rd(16'h5000, 8'h83, 1'b1, "R2 write below window ignored");
    do_wr(16'hC000, 8'hFC);
    do_rd(16'h5000, 8'h83, 1'b1, "R3 low bits 0");
    do_rd(16'h4FFF, 8'h00, 1'b0, "R4 below window");
    do_rd(16'h8000, 8'h00, 1'b0, "R4 above window");
  endtask

  task automatic t_modes;
    do_wr(16'h5000, 8'h1F);
    chk_banks("R6 bit7 clear", sh6, sh7, 8'd30, 8'd31);
    sh6 = 8'h05; sh7 = 8'h06; #1;
    chk_banks("R6 shadow follows", 8'h05, 8'h06, 8'd30, 8'd31);
    do_wr(16'h6000, 8'hE5);
    chk_banks("R7 div4", 8'd4, 8'd5, 8'd6, 8'd7);
    do_wr(16'h5000, 8'hA5);
    chk_banks("R7 div2", 8'd8, 8'd9, 8'd10, 8'd11);
    do_wr(16'h5000, 8'hBF);
    chk_banks("R7 div2 max", 8'd60, 8'd61, 8'd62, 8'd63);
    do_wr(16'h6000, 8'h85);
    chk_banks("R8 16k mirror", 8'd10, 8'd11, 8'd10, 8'd11);
    do_wr(16'h5000, 8'h9F);
    chk_banks("R8 16k max", 8'd62, 8'd63, 8'd62, 8'd63);
    do_rd(16'h5000, 8'h00, 1'b1, "R2 mode write recorded");
  endtask

  task automatic t_rereset;
    do_reset();
    chk_banks("R9 passthrough restored", ns0, ns1, ns2, ns3);
    do_rd(16'h6000, 8'h83, 1'b1, "R9 last byte cleared");
    do_wr(16'h6000, 8'h00);
    chk_banks("R1 zero mode loads, R6 map", sh6, sh7, 8'd30, 8'd31);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_modes();
    t_rereset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule